// File: doc/BRIEF.md
# Two-Group Edge-Triggered Interrupt Merger

This block folds eight status lines into a single active-low interrupt request that is either driven low or left floating. The lines form two groups of four. Group one carries alarm and synchronisation conditions: a superframe yellow alarm, an extended-superframe yellow alarm, a slip indication and a sync-loss indication. Group two carries error-event sources: a severe error, a framing error, a CRC error and a bipolar violation.

A single arm bit moves the block through three states. In Cleared the arm bit is low and the request floats. In Armed the arm bit is high and the request still floats. In Triggered the arm bit is high and the request is driven low. Only an edge that arrives while the block is Armed can trigger it. The request is modelled as an output-enable plus a data value instead of a true tri-state.

Each trigger leaves a latched per-source flag that software can read. Group-one flags are wiped when the block is disarmed. Group-two flags are removed with per-source clear strobes. The severe-error flag is also removed by disarming.

Top module: `dual_group_irq`

## Requirements
- R1: After reset the block is Cleared, `irqOe` is 0 and all flags are 0. A source that is already high during reset produces no edge afterwards, so arming and waiting does not trigger.
- R2: While the arm bit is low every source is ignored. An edge seen in that state never triggers, even if the source stays high after arming.
- R3: While Armed, a rising edge on any group-two bit triggers the block: `irqOe` reads 1 from the next clock, `irqData` reads 0, and that source's flag is set. Group-two bit positions are: 0 severe error, 1 framing, 2 CRC, 3 bipolar violation.
- R4: Group-one bit 2 (slip) fires on any change of state, including a falling one. Group-one bits 0, 1 and 3 (superframe yellow, extended yellow, sync loss) fire only on a rising edge.
- R5: A group-one edge qualifies only while every other group-one level source (bits 0, 1 and 3, not counting itself) is low. Two level sources rising together therefore do not trigger, and at most one group-one flag is ever set.
- R6: Once Triggered, the block stays Triggered whatever the sources do until the arm bit goes low. From the clock after the arm bit goes low the block is Cleared with `irqOe` at 0. Raising the arm bit re-arms it.
- R7: After clear and re-arm with a group-one level source still high, group-one edges cannot trigger but a group-two edge can. Group one can trigger again once all its level sources have returned to 0.
- R8: If a qualifying group-one edge and a group-two edge arrive in the same Armed cycle, group one wins: its flag is set and no group-two flag is set.
- R9: A group-two flag is cleared by its bit of `grpTwoClr`. The severe-error flag (bit 0) is also cleared when the arm bit is low. The other group-two flags survive disarming.
- R10: The group-one flag of the source that triggered is set together with `irqOe`. All group-one flags are cleared when the arm bit goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| armBit | input | 1 | Acknowledge/arm control: 0 clears, 1 arms |
| grpOneIn | input | 4 | Group-one status levels (0 SF yellow, 1 ESF yellow, 2 slip, 3 sync loss) |
| grpTwoIn | input | 4 | Group-two status levels (0 severe, 1 framing, 2 CRC, 3 bipolar) |
| grpTwoClr | input | 4 | Per-source clear strobes for group-two flags |
| irqOe | output | 1 | Request output enable (1 = driven) |
| irqData | output | 1 | Request value when driven (active low) |
| grpOneFlag | output | 4 | Latched group-one trigger flags |
| grpTwoFlag | output | 4 | Latched group-two trigger flags |

## Verification
The functions that can fall in the same cycle are the group-one trigger and the group-two trigger. Both decide from the same Armed cycle, and they compete for the single state change and for the flag updates. The bench provokes this by raising a group-one level source and a group-two source on the same clock while the block is Armed. It then judges the result one cycle later: `irqOe` must be 1, the group-one flag must be set, and the group-two flags must be zero.

// File: rtl/grpirq_pkg.sv
package grpirq_pkg;

  typedef enum logic [1:0] {
    ST_CLEARED = 2'd0,
    ST_ARMED   = 2'd1,
    ST_TRIG    = 2'd2
  } irqState_t;

  // control -> datapath
  typedef struct packed {
    logic takeG1;   // group-one trigger accepted this cycle
    logic takeG2;   // group-two trigger accepted this cycle
    logic disarm;   // arm bit low: wipe arm-cleared flags
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic g1Hit;    // at least one qualified group-one edge
    logic g2Hit;    // at least one group-two rising edge
  } dpStatus_t;

endpackage

// File: rtl/grpirq_datapath.sv
module grpirq_datapath
  import grpirq_pkg::*;
#(
  parameter int GRP_W      = 4,
  parameter int TOGGLE_BIT = 2,
  parameter int ARMCLR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] grpOneIn,
  input  logic [GRP_W-1:0] grpTwoIn,
  input  logic [GRP_W-1:0] grpTwoClr,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic [GRP_W-1:0] grpOneFlag,
  output logic [GRP_W-1:0] grpTwoFlag
);

  localparam logic [GRP_W-1:0] TOGGLE_SEL = GRP_W'(1) << TOGGLE_BIT;
  localparam logic [GRP_W-1:0] LEVEL_MASK = ~TOGGLE_SEL;

  logic [GRP_W-1:0] prevOne;
  logic [GRP_W-1:0] prevTwo;
  logic [GRP_W-1:0] oneEdge;
  logic [GRP_W-1:0] oneQual;
  logic [GRP_W-1:0] twoEdge;
  logic [GRP_W-1:0] oneLevels;

  assign oneLevels = grpOneIn & LEVEL_MASK;

  // previous-value registers; reset loads the live inputs so no false edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevOne <= grpOneIn;
      prevTwo <= grpTwoIn;
    end else begin
      prevOne <= grpOneIn;
      prevTwo <= grpTwoIn;
    end
  end

  // group one: per-bit edge kind and the "others quiet" qualification
  for (genvar i = 0; i < GRP_W; i++) begin : g_one
    localparam logic [GRP_W-1:0] SELF = GRP_W'(1) << i;
    logic othersQuiet;
    if (i == TOGGLE_BIT) begin : g_toggle
      assign oneEdge[i] = grpOneIn[i] ^ prevOne[i];
    end else begin : g_rise
      assign oneEdge[i] = grpOneIn[i] & ~prevOne[i];
    end
    assign othersQuiet = ((oneLevels & ~SELF) == '0);
    assign oneQual[i]  = oneEdge[i] & othersQuiet;
  end

  assign twoEdge = grpTwoIn & ~prevTwo;

  assign status.g1Hit = |oneQual;
  assign status.g2Hit = |twoEdge;

  // group-one flags: set on an accepted trigger, wiped on disarm
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grpOneFlag <= '0;
    end else if (strobe.disarm) begin
      grpOneFlag <= '0;
    end else if (strobe.takeG1) begin
      grpOneFlag <= grpOneFlag | oneQual;
    end
  end

  // group-two flags: per-source clear; one bit also cleared by disarm
  for (genvar j = 0; j < GRP_W; j++) begin : g_two
    logic wipe;
    if (j == ARMCLR_BIT) begin : g_armclr
      assign wipe = grpTwoClr[j] | strobe.disarm;
    end else begin : g_plain
      assign wipe = grpTwoClr[j];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grpTwoFlag[j] <= 1'b0;
      end else if (strobe.takeG2 && twoEdge[j]) begin
        grpTwoFlag[j] <= 1'b1;
      end else if (wipe) begin
        grpTwoFlag[j] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/grpirq_control.sv
module grpirq_control
  import grpirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armBit,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        irqOe
);

  irqState_t stateQ;
  irqState_t stateD;
  logic      armedNow;

  assign armedNow = (stateQ == ST_ARMED) && armBit;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_CLEARED: if (armBit) stateD = ST_ARMED;
      ST_ARMED: begin
        if (!armBit)                           stateD = ST_CLEARED;
        else if (status.g1Hit || status.g2Hit) stateD = ST_TRIG;
      end
      ST_TRIG:    if (!armBit) stateD = ST_CLEARED;
      default:    stateD = ST_CLEARED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_CLEARED;
    else        stateQ <= stateD;
  end

  // group one has priority over group two in the same cycle
  assign strobe.takeG1 = armedNow && status.g1Hit;
  assign strobe.takeG2 = armedNow && status.g2Hit && !status.g1Hit;
  assign strobe.disarm = !armBit;

  assign irqOe = (stateQ == ST_TRIG);

endmodule

// File: rtl/dual_group_irq.sv
module dual_group_irq
  import grpirq_pkg::*;
#(
  parameter int GRP_W      = 4,
  parameter int TOGGLE_BIT = 2,
  parameter int ARMCLR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armBit,
  input  logic [GRP_W-1:0] grpOneIn,
  input  logic [GRP_W-1:0] grpTwoIn,
  input  logic [GRP_W-1:0] grpTwoClr,
  output logic             irqOe,
  output logic             irqData,
  output logic [GRP_W-1:0] grpOneFlag,
  output logic [GRP_W-1:0] grpTwoFlag
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  grpirq_datapath #(
    .GRP_W(GRP_W), .TOGGLE_BIT(TOGGLE_BIT), .ARMCLR_BIT(ARMCLR_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .grpOneIn(grpOneIn), .grpTwoIn(grpTwoIn), .grpTwoClr(grpTwoClr),
    .strobe(strobe), .status(status),
    .grpOneFlag(grpOneFlag), .grpTwoFlag(grpTwoFlag)
  );

  grpirq_control u_ctl (
    .clk(clk), .rst_n(rst_n), .armBit(armBit),
    .status(status), .strobe(strobe), .irqOe(irqOe)
  );

  // request is active low whenever it is driven
  assign irqData = 1'b0;

endmodule

// File: rtl/grpirq_checker.sv
module grpirq_checker #(
  parameter int GRP_W      = 4,
  parameter int ARMCLR_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armBit,
  input logic             irqOe,
  input logic [GRP_W-1:0] grpOneFlag,
  input logic [GRP_W-1:0] grpTwoFlag
);

  AST_DISARM_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !armBit |=> !irqOe); // R6

  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOe && armBit) |=> irqOe); // R6

  AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOe) |-> $past(armBit)); // R2

  AST_G1_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grpOneFlag)); // R5

  AST_G1_FLAG_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !armBit |=> (grpOneFlag == '0)); // R10

  AST_G1_FLAG_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grpOneFlag != '0) |-> irqOe); // R10

  AST_SEVERE_ARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !armBit |=> !grpTwoFlag[ARMCLR_BIT]); // R9

endmodule

bind dual_group_irq grpirq_checker #(.GRP_W(GRP_W), .ARMCLR_BIT(ARMCLR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .armBit(armBit), .irqOe(irqOe),
  .grpOneFlag(grpOneFlag), .grpTwoFlag(grpTwoFlag)
);

// File: tb/dual_group_irq_bench.sv
module dual_group_irq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       armBit = 1'b0;
  logic [3:0] grpOneIn = '0;
  logic [3:0] grpTwoIn = '0;
  logic [3:0] grpTwoClr = '0;
  logic       irqOe;
  logic       irqData;
  logic [3:0] grpOneFlag;
  logic [3:0] grpTwoFlag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_group_irq u_dual_group_irq (
    .clk(clk), .rst_n(rst_n), .armBit(armBit),
    .grpOneIn(grpOneIn), .grpTwoIn(grpTwoIn), .grpTwoClr(grpTwoClr),
    .irqOe(irqOe), .irqData(irqData),
    .grpOneFlag(grpOneFlag), .grpTwoFlag(grpTwoFlag)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiesce();
    armBit = 1'b0; grpOneIn = '0; grpTwoIn = '0; grpTwoClr = 4'hF;
    tick(); tick();
    grpTwoClr = '0;
  endtask

  task automatic t_reset();
    grpOneIn = 4'b0001; grpTwoIn = 4'b0100;
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 oe in reset", 32'(irqOe), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 g1 flags", 32'(grpOneFlag), 0);
    chk("R1 g2 flags", 32'(grpTwoFlag), 0);
    armBit = 1'b1;
    tick(); tick(); tick();
    chk("R1 no false edge", 32'(irqOe), 0);
    quiesce();
  endtask

  task automatic t_cleared_ignored();
    quiesce();
    grpOneIn[3] = 1'b1; grpTwoIn[1] = 1'b1;
    tick();
    armBit = 1'b1;
    tick(); tick();
    chk("R2 edge while cleared", 32'(irqOe), 0);
    chk("R2 no g2 flag", 32'(grpTwoFlag), 0);
  endtask

  task automatic t_g2_trigger();
    quiesce();
    armBit = 1'b1; tick();
    grpTwoIn[2] = 1'b1;
    tick();
    chk("R3 oe", 32'(irqOe), 1);
    chk("R3 data low", 32'(irqData), 0);
    chk("R3 crc flag", 32'(grpTwoFlag), 32'h4);
  endtask

  task automatic t_slip_fall();
    quiesce();
    grpOneIn[2] = 1'b1; tick();
    armBit = 1'b1; tick();
    grpOneIn[2] = 1'b0;
    tick();
    chk("R4 slip fall triggers", 32'(irqOe), 1);
    chk("R4 slip flag", 32'(grpOneFlag), 32'h4);
    quiesce();
    grpOneIn[0] = 1'b1; tick();
    armBit = 1'b1; tick();
    grpOneIn[0] = 1'b0;
    tick();
    chk("R4 level fall ignored", 32'(irqOe), 0);
  endtask

  task automatic t_qualify();
    quiesce();
    grpOneIn[3] = 1'b1; tick();
    armBit = 1'b1; tick();
    grpOneIn[0] = 1'b1;
    tick();
    chk("R5 other level high blocks", 32'(irqOe), 0);
    grpOneIn[2] = 1'b1;
    tick();
    chk("R5 slip blocked by level", 32'(irqOe), 0);
    quiesce();
    armBit = 1'b1; tick();
    grpOneIn[0] = 1'b1; grpOneIn[1] = 1'b1;
    tick();
    chk("R5 double rise no trigger", 32'(irqOe), 0);
    chk("R5 no flag", 32'(grpOneFlag), 0);
  endtask

  task automatic t_hold_rearm();
    quiesce();
    armBit = 1'b1; tick();
    grpTwoIn[1] = 1'b1;
    tick();
    chk("R6 triggered", 32'(irqOe), 1);
    grpOneIn[0] = 1'b1; grpTwoIn[3] = 1'b1;
    tick(); tick();
    chk("R6 holds", 32'(irqOe), 1);
    chk("R6 no new g2 flag", 32'(grpTwoFlag), 32'h2);
    armBit = 1'b0;
    tick();
    chk("R6 disarm releases", 32'(irqOe), 0);
    grpTwoIn[3] = 1'b0; grpOneIn[0] = 1'b0;
    armBit = 1'b1;
    tick();
    chk("R6 rearm floats", 32'(irqOe), 0);
    grpTwoIn[3] = 1'b1;
    tick();
    chk("R6 rearm triggers", 32'(irqOe), 1);
  endtask

  task automatic t_lockout();
    quiesce();
    armBit = 1'b1; tick();
    grpOneIn[1] = 1'b1;
    tick();
    chk("R10 g1 trigger", 32'(irqOe), 1);
    chk("R10 g1 flag set", 32'(grpOneFlag), 32'h2);
    armBit = 1'b0;
    tick();
    chk("R10 g1 flag wiped", 32'(grpOneFlag), 0);
    armBit = 1'b1; tick();
    grpOneIn[2] = 1'b1;
    tick();
    chk("R7 g1 locked", 32'(irqOe), 0);
    grpTwoIn[2] = 1'b1;
    tick();
    chk("R7 g2 still triggers", 32'(irqOe), 1);
    armBit = 1'b0; grpOneIn[1] = 1'b0;
    tick();
    armBit = 1'b1; tick();
    grpOneIn[2] = 1'b0;
    tick();
    chk("R7 g1 after quiet", 32'(irqOe), 1);
    chk("R7 slip flag", 32'(grpOneFlag), 32'h4);
  endtask

  task automatic t_same_cycle();
    quiesce();
    armBit = 1'b1; tick();
    grpOneIn[3] = 1'b1; grpTwoIn[0] = 1'b1;
    tick();
    chk("R8 oe", 32'(irqOe), 1);
    chk("R8 g1 wins", 32'(grpOneFlag), 32'h8);
    chk("R8 g2 not flagged", 32'(grpTwoFlag), 0);
  endtask

  task automatic t_g2_clear();
    quiesce();
    armBit = 1'b1; tick();
    grpTwoIn[1] = 1'b1;
    tick();
    chk("R9 framing flag", 32'(grpTwoFlag), 32'h2);
    armBit = 1'b0;
    tick();
    chk("R9 survives disarm", 32'(grpTwoFlag), 32'h2);
    armBit = 1'b1; tick();
    grpTwoIn[0] = 1'b1;
    tick();
    chk("R9 severe flag", 32'(grpTwoFlag), 32'h3);
    armBit = 1'b0;
    tick();
    chk("R9 severe cleared by disarm", 32'(grpTwoFlag), 32'h2);
    grpTwoClr = 4'b0010;
    tick();
    grpTwoClr = '0;
    chk("R9 strobe clears", 32'(grpTwoFlag), 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cleared_ignored();
    t_g2_trigger();
    t_slip_fall();
    t_qualify();
    t_hold_rearm();
    t_lockout();
    t_same_cycle();
    t_g2_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule